// File: doc/BRIEF.md
# Bit-Serial Exception Coprocessor

This block is the system coprocessor of a small bit-serial processor core. It watches a set of exception request lines. When one of them is accepted, it records where the fault happened and why. It clears the interrupt-enable bit and pulses a redirect output so that the core fetches from a fixed handler address. The block does no arithmetic of its own.

Software reaches the four coprocessor registers through the same serial path the core uses for data memory. Each register is a shift register. While an access is active, the selected register moves one bit per clock. Its least significant bit appears on the serial output, and the serial input enters at the most significant bit. A full 32-clock pass therefore reads the old value and writes a new one, and software restores a value simply by shifting it back in.

Each synchronous exception class can be removed when the block is built: overflow, coprocessor unusable, reserved instruction and address error. Removing address-error support also removes the register that holds the faulting address.

Top module: `exc_cop0`

## Requirements
- R1: After synchronous reset, the interrupt-enable bit is 0, all four registers read as zero and `redirect_o` is 0.
- R2: An accepted exception drives `redirect_o` high for exactly one clock, in the cycle after the request, and `vector_pc_o` always equals the HANDLER_PC parameter (default 0x80).
- R3: The return-address register (select 2) captures the value of `pc_i` from the cycle in which the exception was accepted.
- R4: The cause register (select 1) is loaded with the 5-bit code in bits 6:2 and zero in every other bit. The codes are 4 for a load address error, 5 for a store address error, 10 for a reserved instruction, 11 for coprocessor unusable, 12 for overflow and 0 for an interrupt.
- R5: When several requests arrive in the same cycle, only one code is recorded. The order from highest to lowest is load address error, store address error, reserved instruction, coprocessor unusable, overflow, interrupt.
- R6: `irq_i` is accepted only while the enable bit (status bit 0) is 1. Otherwise it causes no redirect and leaves every register unchanged.
- R7: Accepting any exception clears status bit 0 and keeps status bits 31:1.
- R8: The bad-address register (select 3) loads `fault_addr_i` on an address error only. Any other exception leaves it unchanged.
- R9: While `acc_en_i` is 1, the register chosen by `acc_sel_i` (0 status, 1 cause, 2 return address, 3 bad address) shifts right once per clock. `sdo_o` shows its bit 0 before the shift, and `sdi_i` enters bit 31. Registers that are not selected keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_err_i | input | 1 | Load address error request |
| st_err_i | input | 1 | Store address error request |
| resv_i | input | 1 | Reserved instruction request |
| cpu_i | input | 1 | Coprocessor unusable request |
| ovf_i | input | 1 | Arithmetic overflow request |
| irq_i | input | 1 | External interrupt request |
| pc_i | input | 32 | Address of the current instruction |
| fault_addr_i | input | 32 | Offending data address for address errors |
| acc_en_i | input | 1 | Serial access active: selected register shifts |
| acc_sel_i | input | 2 | Register select for serial access |
| sdi_i | input | 1 | Serial write data |
| sdo_o | output | 1 | Serial read data (bit 0 of the selected register) |
| redirect_o | output | 1 | One-cycle pulse: fetch from the handler address |
| vector_pc_o | output | 32 | Fixed handler address |

## Verification
Each exception class is raised alone, and the cause code read back shows whether the code mapping is right. The classes are then raised in overlapping groups: all six at once, three synchronous classes, two neighbours, and overflow together with an interrupt. These groups separate a correct priority chain from one with two neighbouring entries swapped. Interrupts are raised once with the enable bit clear and once with it set, which shows whether the mask is applied. The bad-address register is read after a non-address exception, which shows whether it is loaded when it should not be. Serial passes with distinct bit patterns on one register, followed by reads of the others, confirm the shift direction and that the select decoding touches only the chosen register.

// File: rtl/exc_cop0_pkg.sv
package exc_cop0_pkg;
  localparam int CODE_W   = 5;
  localparam int CODE_LSB = 2;

  localparam logic [CODE_W-1:0] CODE_INT   = 5'd0;
  localparam logic [CODE_W-1:0] CODE_ADEL  = 5'd4;
  localparam logic [CODE_W-1:0] CODE_ADES  = 5'd5;
  localparam logic [CODE_W-1:0] CODE_RESV  = 5'd10;
  localparam logic [CODE_W-1:0] CODE_CPU   = 5'd11;
  localparam logic [CODE_W-1:0] CODE_OVF   = 5'd12;

  typedef enum logic [1:0] {
    SEL_STAT  = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_EPC   = 2'd2,
    SEL_BAD   = 2'd3
  } cop_sel_e;
endpackage

// File: rtl/exc_ser_reg.sv
module exc_ser_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         sh,
  input  logic         sdi,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= ld_val;
    else if (sh) q <= {sdi, q[W-1:1]};
  end
endmodule

// File: rtl/exc_prio.sv
module exc_prio
  import exc_cop0_pkg::*;
#(
  parameter bit EN_OVF  = 1'b1,
  parameter bit EN_CPU  = 1'b1,
  parameter bit EN_RESV = 1'b1,
  parameter bit EN_ADDR = 1'b1
) (
  input  logic              ld_err,
  input  logic              st_err,
  input  logic              resv,
  input  logic              cpu,
  input  logic              ovf,
  input  logic              irq,
  input  logic              ie,
  output logic              take,
  output logic              addr_hit,
  output logic [CODE_W-1:0] code
);
  logic ld_m, st_m, resv_m, cpu_m, ovf_m;

  generate
    if (EN_ADDR) begin : g_addr
      assign ld_m = ld_err;
      assign st_m = st_err;
    end else begin : g_no_addr
      assign ld_m = 1'b0;
      assign st_m = 1'b0;
    end
    if (EN_RESV) begin : g_resv
      assign resv_m = resv;
    end else begin : g_no_resv
      assign resv_m = 1'b0;
    end
    if (EN_CPU) begin : g_cpu
      assign cpu_m = cpu;
    end else begin : g_no_cpu
      assign cpu_m = 1'b0;
    end
    if (EN_OVF) begin : g_ovf
      assign ovf_m = ovf;
    end else begin : g_no_ovf
      assign ovf_m = 1'b0;
    end
  endgenerate

  always_comb begin
    take     = 1'b1;
    addr_hit = 1'b0;
    code     = CODE_INT;
    if (ld_m) begin
      code     = CODE_ADEL;
      addr_hit = 1'b1;
    end else if (st_m) begin
      code     = CODE_ADES;
      addr_hit = 1'b1;
    end else if (resv_m) begin
      code = CODE_RESV;
    end else if (cpu_m) begin
      code = CODE_CPU;
    end else if (ovf_m) begin
      code = CODE_OVF;
    end else if (!(irq && ie)) begin
      take = 1'b0;
    end
  end
endmodule

// File: rtl/exc_cop0.sv
module exc_cop0
  import exc_cop0_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h0000_0080,
  parameter bit              EN_OVF     = 1'b1,
  parameter bit              EN_CPU     = 1'b1,
  parameter bit              EN_RESV    = 1'b1,
  parameter bit              EN_ADDR    = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_err_i,
  input  logic            st_err_i,
  input  logic            resv_i,
  input  logic            cpu_i,
  input  logic            ovf_i,
  input  logic            irq_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] fault_addr_i,
  input  logic            acc_en_i,
  input  logic [1:0]      acc_sel_i,
  input  logic            sdi_i,
  output logic            sdo_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] vector_pc_o
);
  localparam int NREG = 4;
  localparam int PAD  = XLEN - CODE_W - CODE_LSB;

  logic [XLEN-1:0]   stat_q, cause_q, epc_q, bad_q;
  logic              take, addr_hit;
  logic [CODE_W-1:0] code;
  logic [NREG-1:0]   sh;
  cop_sel_e          sel;

  assign sel = cop_sel_e'(acc_sel_i);

  exc_prio #(
    .EN_OVF(EN_OVF), .EN_CPU(EN_CPU), .EN_RESV(EN_RESV), .EN_ADDR(EN_ADDR)
  ) prio_i (
    .ld_err(ld_err_i), .st_err(st_err_i), .resv(resv_i), .cpu(cpu_i),
    .ovf(ovf_i), .irq(irq_i), .ie(stat_q[0]),
    .take(take), .addr_hit(addr_hit), .code(code)
  );

  generate
    for (genvar k = 0; k < NREG; k++) begin : g_sh
      assign sh[k] = acc_en_i && (acc_sel_i == k[1:0]) && !take;
    end
  endgenerate

  exc_ser_reg #(.W(XLEN)) stat_i (
    .clk(clk), .rst(rst), .ld(take), .ld_val({stat_q[XLEN-1:1], 1'b0}),
    .sh(sh[SEL_STAT]), .sdi(sdi_i), .q(stat_q)
  );

  exc_ser_reg #(.W(XLEN)) cause_i (
    .clk(clk), .rst(rst), .ld(take),
    .ld_val({{PAD{1'b0}}, code, {CODE_LSB{1'b0}}}),
    .sh(sh[SEL_CAUSE]), .sdi(sdi_i), .q(cause_q)
  );

  exc_ser_reg #(.W(XLEN)) epc_i (
    .clk(clk), .rst(rst), .ld(take), .ld_val(pc_i),
    .sh(sh[SEL_EPC]), .sdi(sdi_i), .q(epc_q)
  );

  generate
    if (EN_ADDR) begin : g_bad
      exc_ser_reg #(.W(XLEN)) bad_i (
        .clk(clk), .rst(rst), .ld(take && addr_hit), .ld_val(fault_addr_i),
        .sh(sh[SEL_BAD]), .sdi(sdi_i), .q(bad_q)
      );
    end else begin : g_no_bad
      assign bad_q = '0;
    end
  endgenerate

  always_comb begin
    case (sel)
      SEL_STAT:  sdo_o = stat_q[0];
      SEL_CAUSE: sdo_o = cause_q[0];
      SEL_EPC:   sdo_o = epc_q[0];
      default:   sdo_o = bad_q[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) redirect_o <= 1'b0;
    else     redirect_o <= take;
  end

  assign vector_pc_o = HANDLER_PC;
endmodule

// File: rtl/exc_cop0_chk.sv
module exc_cop0_chk #(
  parameter int XLEN    = 32,
  parameter bit EN_RESV = 1'b1,
  parameter bit EN_ADDR = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic            ld_err_i,
  input logic            st_err_i,
  input logic            resv_i,
  input logic            cpu_i,
  input logic            ovf_i,
  input logic            ie,
  input logic            redirect_o,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] epc_q,
  input logic [XLEN-1:0] cause_q
);
  logic sync_any;
  assign sync_any = ld_err_i | st_err_i | resv_i | cpu_i | ovf_i;

  AST_SYNC_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    (EN_RESV && resv_i) |=> redirect_o);                          // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (redirect_o && !sync_any) |=> !redirect_o);                   // R2
  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> (epc_q == $past(pc_i)));                       // R3
  AST_LOAD_ADDR_CODE: assert property (@(posedge clk) disable iff (rst)
    (EN_ADDR && ld_err_i) |=> (cause_q[6:2] == 5'd4));            // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!ie && !sync_any) |=> !redirect_o);                          // R6
  AST_IE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> !ie);                                          // R7
endmodule

bind exc_cop0 exc_cop0_chk #(
  .XLEN(XLEN), .EN_RESV(EN_RESV), .EN_ADDR(EN_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .ld_err_i(ld_err_i), .st_err_i(st_err_i),
  .resv_i(resv_i), .cpu_i(cpu_i), .ovf_i(ovf_i), .ie(stat_q[0]),
  .redirect_o(redirect_o), .pc_i(pc_i), .epc_q(epc_q), .cause_q(cause_q)
);

// File: tb/exc_cop0_tb_top.sv
module exc_cop0_tb_top;
  localparam logic [31:0] HANDLER = 32'h0000_0080;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_err = 0, st_err = 0, resv = 0, cpu = 0, ovf = 0, irq = 0;
  logic [31:0] pc = '0, fa = '0;
  logic        acc_en = 0, sdi = 0;
  logic [1:0]  acc_sel = '0;
  logic        sdo, redirect;
  logic [31:0] vector_pc;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  exc_cop0 dut_i (
    .clk(clk), .rst(rst), .ld_err_i(ld_err), .st_err_i(st_err),
    .resv_i(resv), .cpu_i(cpu), .ovf_i(ovf), .irq_i(irq),
    .pc_i(pc), .fault_addr_i(fa), .acc_en_i(acc_en), .acc_sel_i(acc_sel),
    .sdi_i(sdi), .sdo_o(sdo), .redirect_o(redirect), .vector_pc_o(vector_pc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected redirect per observed pulse
  always @(negedge clk) begin
    if (!rst && redirect) begin
      if (exp_q.size() == 0) chk("R2/R6 unexpected redirect", 32'd1, 32'd0);
      else begin
        void'(exp_q.pop_front());
        chk("R2 handler address", vector_pc, HANDLER);
      end
    end
  end

  task automatic xfer(input logic [1:0] s, input logic [31:0] w, output logic [31:0] r);
    @(negedge clk);
    acc_en = 1'b1;
    acc_sel = s;
    for (int i = 0; i < 32; i++) begin
      sdi = w[i];
      #1;
      r[i] = sdo;
      @(negedge clk);
    end
    acc_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] r);
    logic [31:0] dummy;
    xfer(s, 32'h0, r);
    xfer(s, r, dummy);
  endtask

  // req bits: [5] ld, [4] st, [3] resv, [2] cpu, [1] ovf, [0] irq
  task automatic raise(input logic [5:0] req, input logic [31:0] p,
                       input logic [31:0] f, input bit expect_take);
    @(negedge clk);
    {ld_err, st_err, resv, cpu, ovf, irq} = req;
    pc = p;
    fa = f;
    if (expect_take) exp_q.push_back(1);
    @(negedge clk);
    {ld_err, st_err, resv, cpu, ovf, irq} = '0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 redirect after reset", {31'b0, redirect}, 32'h0);
    rd(2'd0, r); chk("R1 status", r, 32'h0);
    rd(2'd1, r); chk("R1 cause", r, 32'h0);
    rd(2'd2, r); chk("R1 epc", r, 32'h0);
    rd(2'd3, r); chk("R1 bad", r, 32'h0);

    // R9 serial write then read, unselected untouched
    xfer(2'd2, 32'hA5A5_0F0F, r); chk("R9 old epc out", r, 32'h0);
    xfer(2'd2, 32'h0, r);         chk("R9 epc written", r, 32'hA5A5_0F0F);
    xfer(2'd3, 32'h1357_9BDF, r);
    rd(2'd3, r);                  chk("R9 bad written", r, 32'h1357_9BDF);
    rd(2'd0, r);                  chk("R9 status unselected", r, 32'h0);
    xfer(2'd3, 32'h0, r);

    // R6 masked interrupt
    raise(6'b000001, 32'h40, 32'h0, 1'b0);
    rd(2'd2, r); chk("R6 epc untouched", r, 32'h0);
    rd(2'd1, r); chk("R6 cause untouched", r, 32'h0);

    // interrupt accepted with enable set
    xfer(2'd0, 32'hFFFF_0001, r);
    rd(2'd0, r); chk("R9 status written", r, 32'hFFFF_0001);
    xfer(2'd1, 32'hFFFF_FFFF, r);
    raise(6'b000001, 32'h100, 32'h0, 1'b1);
    rd(2'd1, r); chk("R4 interrupt code", r, 32'h0);
    rd(2'd2, r); chk("R3 epc irq", r, 32'h100);
    rd(2'd0, r); chk("R7 enable cleared", r, 32'hFFFF_0000);
    raise(6'b000001, 32'h104, 32'h0, 1'b0);
    rd(2'd2, r); chk("R6 irq after clear", r, 32'h100);

    // single classes
    raise(6'b000010, 32'h200, 32'hDEAD, 1'b1);
    rd(2'd1, r); chk("R4 overflow code", r, 32'h30);
    rd(2'd2, r); chk("R3 epc ovf", r, 32'h200);
    rd(2'd3, r); chk("R8 bad not loaded", r, 32'h0);
    raise(6'b000100, 32'h204, 32'h0, 1'b1);
    rd(2'd1, r); chk("R4 cpu code", r, 32'h2C);
    raise(6'b001000, 32'h208, 32'h0, 1'b1);
    rd(2'd1, r); chk("R4 resv code", r, 32'h28);
    raise(6'b010000, 32'h20C, 32'h1235, 1'b1);
    rd(2'd1, r); chk("R4 store addr code", r, 32'h14);
    rd(2'd3, r); chk("R8 bad store", r, 32'h1235);
    raise(6'b100000, 32'h210, 32'h2001, 1'b1);
    rd(2'd1, r); chk("R4 load addr code", r, 32'h10);
    rd(2'd3, r); chk("R8 bad load", r, 32'h2001);
    rd(2'd2, r); chk("R3 epc load", r, 32'h210);
    raise(6'b000010, 32'h214, 32'h9999, 1'b1);
    rd(2'd3, r); chk("R8 bad held", r, 32'h2001);

    // R5 priority
    xfer(2'd0, 32'h1, r);
    raise(6'b111111, 32'h300, 32'h4444, 1'b1);
    rd(2'd1, r); chk("R5 all six", r, 32'h10);
    raise(6'b001110, 32'h304, 32'h0, 1'b1);
    rd(2'd1, r); chk("R5 resv over cpu/ovf", r, 32'h28);
    raise(6'b000110, 32'h308, 32'h0, 1'b1);
    rd(2'd1, r); chk("R5 cpu over ovf", r, 32'h2C);
    xfer(2'd0, 32'h1, r);
    raise(6'b000011, 32'h30C, 32'h0, 1'b1);
    rd(2'd1, r); chk("R5 ovf over irq", r, 32'h30);
    rd(2'd0, r); chk("R7 cleared by ovf", r, 32'h0);
    raise(6'b011000, 32'h310, 32'h5678, 1'b1);
    rd(2'd1, r); chk("R5 store over resv", r, 32'h14);
    rd(2'd3, r); chk("R8 bad store prio", r, 32'h5678);

    repeat (3) @(negedge clk);
    chk("R2 all redirects seen", exp_q.size(), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule